// File: doc/BRIEF.md
# Fractional-N Serial Bit-Rate Generator

This block derives the timing enables for a serial transceiver from one of several source clocks. A 16-bit integer divisor and a 3-bit fraction in eighths set the length of one sampling period. The sampling tick fires once per period. In the asynchronous mode, the baud tick fires on every 8th or 16th sampling tick. The fraction is realised by stretching some periods by one source cycle. A small phase accumulator chooses which periods are stretched, so that every group of eight sampling periods is exactly `8*CD + FP` source periods long.

In the synchronous mode the source is divided by the integer divisor only. The block then also drives a serial clock output. When the system clock is the source, this output keeps a 50:50 duty cycle even for an odd divisor, by adding a half-cycle extension taken from a falling-edge register. The source can be the system clock, the system clock pre-divided by a fixed factor, or an external serial clock. The external clock passes through a two-flop synchronizer, and its rising edges act as the source events.

A new divisor value restarts the divider at once, so no runt period is produced. All other settings wait for the end of the running baud period.

Top module: `frac_baud_gen`

## Requirements
- R1: In asynchronous mode (`cfg_sync`=0), every baud period lasts exactly OS*CD + OS*FP/8 source periods. OS is 16 when `cfg_over8`=0 and 8 when `cfg_over8`=1.
- R2: In asynchronous mode, consecutive sampling ticks are CD or CD+1 source periods apart. In any 8 consecutive sampling periods, exactly FP of them are CD+1 long.
- R3: With CD=0, no sampling or baud tick is produced and `sck_out` stays low, unless external direct mode is active (see R6). With CD=1, every source event is a sampling tick.
- R4: In synchronous mode (`cfg_sync`=1), `baud_tick` and `samp_tick` fire together every CD source periods. FP and `cfg_over8` have no effect in this mode.
- R5: `baud_tick` is only ever high together with `samp_tick`. In asynchronous mode it marks every OS-th sampling tick.
- R6: The `cfg_src` encoding is 0 = system clock, 1 = system clock divided by PREDIV, 2 = same as 0, and 3 = rising edges of `ext_sck` after a two-flop synchronizer. The mode with `cfg_src`=3 and `cfg_sync`=1 is external direct mode: each external rising edge gives one tick and CD is ignored.
- R7: In synchronous mode with CD>=2, `sck_out` behaves as follows. With source 0 or 2, it is high for exactly CD of the 2*CD half-cycles of each period. With source 1, it is high for floor(CD/2) source periods. In external direct mode it follows the synchronized `ext_sck`. In asynchronous mode it is low.
- R8: A change of `cfg_cd` clears the counter and the accumulator at the next clock edge. With the system clock as source, the first baud tick after the change appears P+1 cycles after the edge before that capture, where P is the R1 period.
- R9: Changes to `cfg_fp`, `cfg_over8`, `cfg_sync` and `cfg_src` take effect at the next baud boundary. The running period completes with the old settings.
- R10: While `rst_n` is low, `samp_tick`, `baud_tick` and `sck_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cd | input | 16 | Integer divisor CD |
| cfg_fp | input | 3 | Fraction FP in eighths |
| cfg_over8 | input | 1 | 1 = x8 oversampling, 0 = x16 |
| cfg_sync | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| cfg_src | input | 2 | Source clock select |
| ext_sck | input | 1 | External serial clock |
| samp_tick | output | 1 | One-cycle sampling enable |
| baud_tick | output | 1 | One-cycle bit-rate enable |
| sck_out | output | 1 | Serial clock output (synchronous mode) |

## Verification
A stuck or mis-stepped phase accumulator moves the wrong number of stretch cycles into a baud period. Because each baud period holds a whole multiple of eight sampling periods, the error shows as a wrong tick spacing on the first baud period that follows. A counter that is not cleared on a divisor change shows within one period as a mistimed first tick. A lost falling-edge half-cycle shows within one serial clock period as a high count that is one half-cycle short.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  parameter int CD_W = 16;
  parameter int FP_W = 3;
  parameter int OS_W = 4;

  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_DIV = 2'd1,
    SRC_RSV = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

  typedef struct packed {
    logic [CD_W-1:0] cd;
    logic [FP_W-1:0] fp;
    logic            over8;
    logic            sync;
    src_e            src;
  } cfg_t;

  // accumulator step: carry bit on top of the new phase
  function automatic logic [FP_W:0] acc_step(logic [FP_W-1:0] acc, logic [FP_W-1:0] fp);
    return {1'b0, acc} + {1'b0, fp};
  endfunction

  // source periods in the current divider period
  function automatic logic [CD_W:0] period_len(logic [CD_W-1:0] cd, logic stretch);
    return {1'b0, cd} + {{CD_W{1'b0}}, stretch};
  endfunction

  function automatic logic [OS_W:0] os_ratio(logic over8);
    return over8 ? (OS_W+1)'(8) : (OS_W+1)'(16);
  endfunction
endpackage

// File: rtl/fbg_src_sel.sv
module fbg_src_sel
  import fbg_pkg::*;
#(
  parameter int PREDIV      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic ext_sck,
  output logic src_en,
  output logic ext_rise,
  output logic ext_lvl
);
  localparam int PW = (PREDIV > 2) ? $clog2(PREDIV) : 1;

  logic [SYNC_STAGES:0] sync_q;
  logic [PW-1:0]        pre_cnt;
  logic                 pre_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_sck};
  end

  assign ext_lvl  = sync_q[SYNC_STAGES-1];
  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  assign pre_tick = (pre_cnt == PW'(PREDIV-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (pre_tick) pre_cnt <= '0;
    else               pre_cnt <= pre_cnt + 1'b1;
  end

  always_comb begin
    case (src)
      SRC_DIV: src_en = pre_tick;
      SRC_EXT: src_en = ext_rise;
      default: src_en = 1'b1;
    endcase
  end

  AST_PREDIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick); // R6
  AST_EXT_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise); // R6
endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div
  import fbg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            en,
  input  logic [CD_W-1:0] cd,
  input  logic [FP_W-1:0] fp,
  output logic            wrap,
  output logic [CD_W-1:0] cnt_nxt
);
  logic [CD_W-1:0] cnt_q;
  logic [FP_W-1:0] acc_q;
  logic [FP_W:0]   step;
  logic            stretch;

  // the carry of this period's addition decides its own length
  assign step    = acc_step(acc_q, fp);
  assign stretch = step[FP_W];
  assign wrap    = en && (cd != '0) &&
                   (({1'b0, cnt_q} + 1'b1) == period_len(cd, stretch));

  always_comb begin
    if (restart || wrap)       cnt_nxt = '0;
    else if (en && cd != '0)   cnt_nxt = cnt_q + 1'b1;
    else                       cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (restart)   acc_q <= '0;
      else if (wrap) acc_q <= step[FP_W-1:0];
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cd != '0) |-> (cnt_q <= cd)); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && acc_q == '0)); // R8
endmodule

// File: rtl/fbg_duty.sv
module fbg_duty (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_set,
  input  logic odd_half,
  input  logic ext_mode,
  input  logic ext_lvl,
  output logic sck_out
);
  logic hi_q, hi_n, odd_q, ext_mode_q, ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q       <= 1'b0;
      odd_q      <= 1'b0;
      ext_mode_q <= 1'b0;
      ext_q      <= 1'b0;
    end else begin
      hi_q       <= hi_set;
      odd_q      <= odd_half;
      ext_mode_q <= ext_mode;
      ext_q      <= ext_lvl;
    end
  end

  // half-cycle tail for odd divisors on the system clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hi_n <= 1'b0;
    else        hi_n <= hi_q;
  end

  assign sck_out = ext_mode_q ? ext_q : (hi_q | (odd_q & hi_n));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int PREDIV      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_cd,
  input  logic [2:0]  cfg_fp,
  input  logic        cfg_over8,
  input  logic        cfg_sync,
  input  logic [1:0]  cfg_src,
  input  logic        ext_sck,
  output logic        samp_tick,
  output logic        baud_tick,
  output logic        sck_out
);
  cfg_t            live, act_q;
  logic            cd_write, take_cfg, ext_direct;
  logic            src_en, ext_rise, ext_lvl, wrap;
  logic            os_last, samp_evt, baud_evt;
  logic            hi_set, odd_half;
  logic [FP_W-1:0] fp_eff;
  logic [CD_W-1:0] cnt_nxt;
  logic [OS_W-1:0] os_q;

  assign live = '{cd: cfg_cd, fp: cfg_fp, over8: cfg_over8,
                  sync: cfg_sync, src: src_e'(cfg_src)};

  assign cd_write   = (cfg_cd != act_q.cd);
  assign ext_direct = act_q.sync && (act_q.src == SRC_EXT);
  assign fp_eff     = act_q.sync ? '0 : act_q.fp;
  assign os_last    = ({1'b0, os_q} == os_ratio(act_q.over8) - 1'b1);

  assign samp_evt = ext_direct ? src_en : wrap;
  assign baud_evt = ext_direct ? src_en : (wrap && (act_q.sync || os_last));
  assign take_cfg = cd_write || baud_evt || (act_q.cd == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= '0;
      os_q      <= '0;
      samp_tick <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      if (take_cfg) act_q <= live;
      if (cd_write)                 os_q <= '0;
      else if (wrap && !act_q.sync) os_q <= os_last ? '0 : os_q + 1'b1;
      samp_tick <= samp_evt;
      baud_tick <= baud_evt;
    end
  end

  fbg_src_sel #(.PREDIV(PREDIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .src(act_q.src), .ext_sck(ext_sck),
    .src_en(src_en), .ext_rise(ext_rise), .ext_lvl(ext_lvl)
  );

  fbg_frac_div u_div (
    .clk(clk), .rst_n(rst_n), .restart(cd_write), .en(src_en),
    .cd(act_q.cd), .fp(fp_eff), .wrap(wrap), .cnt_nxt(cnt_nxt)
  );

  assign hi_set   = act_q.sync && !ext_direct && (act_q.cd != '0) &&
                    (cnt_nxt < (act_q.cd >> 1));
  assign odd_half = act_q.sync && act_q.cd[0] &&
                    (act_q.src == SRC_SYS || act_q.src == SRC_RSV);

  fbg_duty u_duty (
    .clk(clk), .rst_n(rst_n), .hi_set(hi_set), .odd_half(odd_half),
    .ext_mode(ext_direct), .ext_lvl(ext_lvl), .sck_out(sck_out)
  );

  AST_CD_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.cd == '0 && !ext_direct) |=> !samp_tick); // R3
  AST_BAUD_NEEDS_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> samp_tick); // R5
  AST_OS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, os_q} < os_ratio(act_q.over8))); // R5
  AST_EXT_UNUSED_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_direct && !ext_rise) |=> !samp_tick); // R6
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  localparam int PREDIV = 4;
  localparam int EXT_P  = 6;
  localparam int NV     = 10;
  // {src[22:21], sync[20], over8[19], fp[18:16], cd[15:0]}
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 3'd0, 16'd4},
    {2'd0, 1'b0, 1'b0, 3'd5, 16'd3},
    {2'd0, 1'b0, 1'b1, 3'd3, 16'd5},
    {2'd0, 1'b0, 1'b1, 3'd7, 16'd1},
    {2'd2, 1'b0, 1'b0, 3'd1, 16'd2},
    {2'd1, 1'b0, 1'b1, 3'd4, 16'd3},
    {2'd0, 1'b1, 1'b1, 3'd5, 16'd7},
    {2'd1, 1'b1, 1'b0, 3'd0, 16'd3},
    {2'd3, 1'b0, 1'b1, 3'd0, 16'd2},
    {2'd3, 1'b1, 1'b0, 3'd0, 16'd9}
  };

  logic clk = 0, rst_n = 0, ext_sck = 0;
  logic [15:0] cfg_cd = 0;
  logic [2:0]  cfg_fp = 0;
  logic        cfg_over8 = 0, cfg_sync = 0;
  logic [1:0]  cfg_src = 0;
  logic samp_tick, baud_tick, sck_out;
  int cyc = 0, errors = 0, checks = 0;

  frac_baud_gen #(.PREDIV(PREDIV)) i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .cfg_cd(cfg_cd), .cfg_fp(cfg_fp),
    .cfg_over8(cfg_over8), .cfg_sync(cfg_sync), .cfg_src(cfg_src),
    .ext_sck(ext_sck), .samp_tick(samp_tick), .baud_tick(baud_tick),
    .sck_out(sck_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  initial forever begin repeat (EXT_P/2) @(posedge clk); #5 ext_sck = ~ext_sck; end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int exp_period(int src, int sync, int over8, int fp, int cd);
    int unit = (src == 1) ? PREDIV : (src == 3) ? EXT_P : 1;
    int os   = over8 ? 8 : 16;
    if (sync) return (src == 3) ? EXT_P : unit * cd;
    return unit * (os * cd + (os * fp) / 8);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(int src, int sync, int over8, int fp, int cd);
    @(posedge clk); #5;
    rst_n = 0;
    cfg_src = 2'(src); cfg_sync = 1'(sync); cfg_over8 = 1'(over8);
    cfg_fp = 3'(fp); cfg_cd = 16'(cd);
    repeat (2) @(posedge clk);
    #5 rst_n = 1;
  endtask

  // returns the cycle of the next tick (baud or sampling), -1 if none in limit
  task automatic next_tick(input bit use_baud, input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); #5;
      if (use_baud ? baud_tick : samp_tick) begin t = cyc; return; end
    end
  endtask

  task automatic count_high(input int ncyc, output int n);
    n = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #5;
      n += int'(sck_out);
      #10;
      n += int'(sck_out);
    end
  endtask

  initial begin
    int t0, t1, t2, n, ones, sum;
    // R10 reset state
    repeat (3) @(posedge clk); #5;
    check("R10 samp_tick in reset", int'(samp_tick), 0);
    check("R10 baud_tick in reset", int'(baud_tick), 0);
    check("R10 sck_out in reset", int'(sck_out), 0);

    // table: R1 async, R4 sync, R6 sources
    for (int v = 0; v < NV; v++) begin
      int src = int'(VEC[v][22:21]);
      int sy  = int'(VEC[v][20]);
      int ov  = int'(VEC[v][19]);
      int fp  = int'(VEC[v][18:16]);
      int cd  = int'(VEC[v][15:0]);
      int p   = exp_period(src, sy, ov, fp, cd);
      setup(src, sy, ov, fp, cd);
      next_tick(1, 4000, t0);
      for (int k = 0; k < 8; k++) begin
        next_tick(1, 4000, t1);
        check(sy ? "R4/R6 sync baud period" : "R1/R6 async baud period",
              (t1 < 0 || t0 < 0) ? -1 : t1 - t0, p);
        t0 = t1;
      end
    end

    // R2 sampling spacing and stretch count
    setup(0, 0, 0, 5, 3);
    next_tick(0, 100, t0);
    ones = 0; sum = 0;
    for (int k = 0; k < 8; k++) begin
      next_tick(0, 100, t1);
      if (t1 - t0 == 4) ones++;
      else check("R2 sampling interval CD", t1 - t0, 3);
      sum += t1 - t0; t0 = t1;
    end
    check("R2 stretched periods in 8", ones, 5);
    check("R2 window length", sum, 29);

    // R3 CD=0 idle, CD=1 every source cycle
    setup(0, 1, 0, 0, 0);
    next_tick(0, 300, t0);
    check("R3 no tick with CD=0", t0, -1);
    count_high(20, n);
    check("R3 sck low with CD=0", n, 0);
    setup(0, 0, 1, 0, 1);
    next_tick(0, 50, t0);
    for (int k = 0; k < 4; k++) begin
      next_tick(0, 50, t1);
      check("R3 CD=1 sampling interval", t1 - t0, 1);
      t0 = t1;
    end

    // R5 baud tick coincides with a sampling tick
    setup(0, 0, 1, 0, 3);
    next_tick(1, 200, t0);
    check("R5 samp_tick with baud_tick", int'(samp_tick), 1);

    // R8 divisor write restarts the period
    setup(0, 0, 0, 0, 4);
    next_tick(1, 200, t0);
    repeat (10) @(posedge clk); #5;
    t1 = cyc; cfg_cd = 16'd3;
    next_tick(1, 200, t2);
    check("R8 first tick after CD write", t2 - t1, 48 + 1);

    // R9 oversampling change waits for the boundary
    setup(0, 0, 0, 0, 2);
    next_tick(1, 200, t0);
    cfg_over8 = 1;
    next_tick(1, 200, t1);
    check("R9 running period keeps old ratio", t1 - t0, 32);
    next_tick(1, 200, t2);
    check("R9 new ratio after boundary", t2 - t1, 16);

    // R7 serial clock duty
    setup(0, 1, 0, 0, 5);
    next_tick(1, 100, t0);
    count_high(5, n);
    check("R7 odd CD sys duty half-cycles", n, 5);
    setup(0, 1, 0, 0, 6);
    next_tick(1, 100, t0);
    count_high(6, n);
    check("R7 even CD sys duty half-cycles", n, 6);
    setup(1, 1, 0, 0, 3);
    next_tick(1, 100, t0);
    count_high(12, n);
    check("R7 predivided source high half-cycles", n, 8);
    setup(0, 0, 0, 0, 4);
    count_high(20, n);
    check("R7 async mode sck low", n, 0);
    setup(3, 1, 0, 0, 9);
    next_tick(1, 100, t0);
    count_high(EXT_P * 2, n);
    check("R7 external direct follows ext clock", n, EXT_P * 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule